// File: doc/BRIEF.md
# Controller Command Responder with Seconds Clock

This block sits behind a byte-serial host transfer engine. Once the engine has collected a complete host packet it presents the packet for a single cycle. The responder decodes the packet and, for the commands it understands, returns a reply packet to the engine on a one-cycle strobe. The reply carries a byte count (at most seven) and a byte array.

The block keeps a 32-bit seconds clock. An external one-pulse-per-second tick advances it, and a command can load it. The count is referenced to midnight, January 1, 1904. Its reset value is a parameter given in 1970-based seconds, and the block adds the fixed epoch offset to it. The block also holds an auto-poll enable flag. While that flag is set, it produces a poll request pulse at a 50 Hz rate, derived from the system clock frequency.

Two commands ask the system to power down or to restart. For each of these, the block first sends its acknowledge and then raises the matching request for exactly one cycle. Packets of any type other than controller commands, unrecognised command codes and packets too short for their command are all dropped silently.

Top module: `ctl_cmd_responder`

## Requirements
- R1: After reset, `rsp_valid`, `poll_req`, `pwrdn_req` and `sysrst_req` are low. Auto-poll is disabled. The seconds clock holds INIT_UNIX + 2082844800 (0x7C25B080 for the default INIT_UNIX of 0).
- R2: Byte 0 of a packet is its type, and only type 0x01 (controller command) is acted on. A packet of any other type (for example 0x00 or 0x02) produces no reply and changes no state.
- R3: Command 0x09 (byte 1) with `pkt_len` ≥ 6 loads the seconds clock with bytes 2..5, taken most significant byte first. It replies with length 3 and bytes 0x01, 0x00, 0x00.
- R4: Command 0x03 with `pkt_len` ≥ 2 replies with length 7. The reply bytes are 0x01, 0x00, 0x00 followed by the seconds count, most significant byte first. The count is the value the clock held in the cycle the packet was accepted.
- R5: The seconds clock advances by one, wrapping modulo 2^32, on each cycle in which `sec_tick` is high. A load from command 0x09 in the same cycle takes priority over the tick.
- R6: Command 0x01 with `pkt_len` ≥ 3 sets the auto-poll flag when byte 2 is nonzero and clears it when byte 2 is zero. It replies with length 2 and bytes 0x01 and the byte 2 value.
- R7: While auto-poll is enabled, `poll_req` is a one-cycle pulse every POLL_DIV = CLK_HZ/POLL_HZ cycles. The first pulse comes POLL_DIV-1 cycles after the enabling reply cycle. While auto-poll is disabled, no pulse appears.
- R8: Commands 0x13, 0x14, 0x19 and 0x21 reply with length 2 and bytes 0x01, 0x00, and have no other effect.
- R9: Command 0x0A replies with length 2 and bytes 0x01, 0x00. It then raises `pwrdn_req` for exactly one cycle, in the cycle after the reply. Command 0x11 behaves the same way but raises `sysrst_req` instead.
- R10: An unrecognised command code, or a controller packet shorter than its command needs, produces no reply and changes no state.
- R11: `rsp_valid` is high for exactly one cycle, in the cycle after `pkt_valid` is sampled high. Reply bytes beyond `rsp_len` are zero. Byte i of `rsp_bytes` occupies bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pkt_valid | input | 1 | One-cycle strobe: a complete host packet is present |
| pkt_len | input | LEN_W (4) | Number of valid bytes in `pkt_bytes` |
| pkt_bytes | input | MAX_IN*8 (64) | Packet bytes; byte i at bits [8i+7:8i] |
| sec_tick | input | 1 | One-cycle pulse once per second |
| rsp_valid | output | 1 | One-cycle strobe: a reply is present |
| rsp_len | output | 3 | Reply byte count (2, 3 or 7) |
| rsp_bytes | output | 56 | Reply bytes; byte i at bits [8i+7:8i] |
| poll_req | output | 1 | Auto-poll request pulse at the poll rate |
| pwrdn_req | output | 1 | One-cycle power-down request |
| sysrst_req | output | 1 | One-cycle system restart request |

## Verification
A corrupted seconds count shows up only through a later time-read reply, and it stays visible on every read after that. For this reason, each scenario ends by reading the clock back, which catches a stray load or tick. A wrong auto-poll flag shows at `poll_req` within POLL_DIV cycles: either a pulse appears that should not, or an expected pulse is missing. A request left pending shows up as a power-down or restart pulse one cycle after the reply, or as one that never arrives. Dropped packets are therefore checked both by the absent strobe and by the unchanged clock and poll behaviour that follow.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int BYTE_W  = 8;
    localparam int RSP_MAX = 7;

    // packet type byte values
    localparam logic [7:0] PKT_TYPE_BUS   = 8'h00;
    localparam logic [7:0] PKT_TYPE_CTL   = 8'h01;
    localparam logic [7:0] PKT_TYPE_ERROR = 8'h02;
    localparam logic [7:0] PKT_TYPE_TIMER = 8'h03;
    localparam logic [7:0] PKT_TYPE_POWER = 8'h04;

    localparam logic [7:0] STATUS_OK = 8'h00;

    // seconds between the 1904 and 1970 epochs
    localparam logic [31:0] EPOCH_1904_OFFSET = 32'd2082844800;

    typedef enum logic [7:0] {
        CMD_POLL_CTRL = 8'h01,
        CMD_TIME_READ = 8'h03,
        CMD_TIME_LOAD = 8'h09,
        CMD_POWER_OFF = 8'h0A,
        CMD_RESTART   = 8'h11,
        CMD_SRV_FLAG  = 8'h13,
        CMD_POLL_RATE = 8'h14,
        CMD_DEV_LIST  = 8'h19,
        CMD_PWR_MSGS  = 8'h21
    } cmd_e;

    typedef enum logic [1:0] {
        SYSREQ_NONE  = 2'd0,
        SYSREQ_POWER = 2'd1,
        SYSREQ_RESET = 2'd2
    } sysreq_e;

    typedef logic [RSP_MAX-1:0][BYTE_W-1:0] rsp_bytes_t;

    typedef struct packed {
        logic        reply;
        logic [2:0]  len;
        rsp_bytes_t  bytes;
        logic        load_time;
        logic [31:0] time_val;
        logic        poll_wr;
        logic        poll_val;
        sysreq_e     sysreq;
    } action_t;

    function automatic logic [31:0] be_word(input logic [7:0] b3, input logic [7:0] b2,
                                            input logic [7:0] b1, input logic [7:0] b0);
        return {b3, b2, b1, b0};
    endfunction

    // acknowledge: type byte then one status byte
    function automatic action_t ack_action(input logic [7:0] second);
        action_t a;
        a          = '0;
        a.reply    = 1'b1;
        a.len      = 3'd2;
        a.bytes[0] = PKT_TYPE_CTL;
        a.bytes[1] = second;
        return a;
    endfunction

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int MAX_IN = 8,
    parameter int LEN_W  = 4
) (
    input  logic [LEN_W-1:0]      pkt_len,
    input  logic [MAX_IN*8-1:0]   pkt_bytes,
    input  logic [31:0]           secs,
    output action_t               act
);

    logic [7:0] b [MAX_IN];

    always_comb begin
        for (int i = 0; i < MAX_IN; i++) begin
            b[i] = pkt_bytes[i*8 +: 8];
        end
    end

    always_comb begin
        act = '0;
        if (pkt_len >= LEN_W'(2) && b[0] == PKT_TYPE_CTL) begin
            case (b[1])
                CMD_TIME_LOAD: begin
                    if (pkt_len >= LEN_W'(6)) begin
                        act           = ack_action(STATUS_OK);
                        act.len       = 3'd3;
                        act.load_time = 1'b1;
                        act.time_val  = be_word(b[2], b[3], b[4], b[5]);
                    end
                end
                CMD_TIME_READ: begin
                    act          = ack_action(STATUS_OK);
                    act.len      = 3'd7;
                    act.bytes[3] = secs[31:24];
                    act.bytes[4] = secs[23:16];
                    act.bytes[5] = secs[15:8];
                    act.bytes[6] = secs[7:0];
                end
                CMD_POLL_CTRL: begin
                    if (pkt_len >= LEN_W'(3)) begin
                        act          = ack_action(b[2]);
                        act.poll_wr  = 1'b1;
                        act.poll_val = (b[2] != 8'h00);
                    end
                end
                CMD_SRV_FLAG, CMD_POLL_RATE, CMD_DEV_LIST, CMD_PWR_MSGS: begin
                    act = ack_action(STATUS_OK);
                end
                CMD_POWER_OFF: begin
                    act        = ack_action(STATUS_OK);
                    act.sysreq = SYSREQ_POWER;
                end
                CMD_RESTART: begin
                    act        = ack_action(STATUS_OK);
                    act.sysreq = SYSREQ_RESET;
                end
                default: act = '0;
            endcase
        end
    end

endmodule

// File: rtl/ccr_seconds.sv
module ccr_seconds
    import ccr_pkg::*;
#(
    parameter logic [31:0] INIT_UNIX = 32'd0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        load,
    input  logic [31:0] load_val,
    output logic [31:0] secs
);

    localparam logic [31:0] RESET_VAL = INIT_UNIX + EPOCH_1904_OFFSET;

    logic [31:0] secs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            secs_q <= RESET_VAL;
        end else if (load) begin
            secs_q <= load_val;
        end else if (tick) begin
            secs_q <= secs_q + 32'd1;
        end
    end

    assign secs = secs_q;

    AST_SEC_LOAD: assert property (@(posedge clk) disable iff (rst)
        load |=> secs == $past(load_val)); // R3
    AST_SEC_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> secs == $past(secs) + 32'd1); // R5
    AST_SEC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!tick && !load) |=> $stable(secs)); // R5

endmodule

// File: rtl/ccr_poll_timer.sv
module ccr_poll_timer #(
    parameter int POLL_DIV = 2_000_000
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic req
);

    localparam int CNT_W = (POLL_DIV > 2) ? $clog2(POLL_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(POLL_DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
        end else if (cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign req = en && (cnt_q == LAST);

    AST_POLL_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        req |-> en); // R7
    AST_POLL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        req |=> !req); // R7

endmodule

// File: rtl/ctl_cmd_responder.sv
module ctl_cmd_responder
    import ccr_pkg::*;
#(
    parameter int          MAX_IN    = 8,
    parameter int          CLK_HZ    = 100_000_000,
    parameter int          POLL_HZ   = 50,
    parameter logic [31:0] INIT_UNIX = 32'd0,
    localparam int         LEN_W     = $clog2(MAX_IN + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pkt_valid,
    input  logic [LEN_W-1:0]      pkt_len,
    input  logic [MAX_IN*8-1:0]   pkt_bytes,
    input  logic                  sec_tick,
    output logic                  rsp_valid,
    output logic [2:0]            rsp_len,
    output logic [RSP_MAX*8-1:0]  rsp_bytes,
    output logic                  poll_req,
    output logic                  pwrdn_req,
    output logic                  sysrst_req
);

    localparam int POLL_DIV = CLK_HZ / POLL_HZ;

    action_t     act;
    logic [31:0] secs;
    logic        accept;

    logic        rsp_valid_q;
    logic [2:0]  rsp_len_q;
    rsp_bytes_t  rsp_bytes_q;
    logic        poll_en_q;
    sysreq_e     pend_q;
    logic        pwr_q;
    logic        sysrst_q;

    ccr_decode #(
        .MAX_IN (MAX_IN),
        .LEN_W  (LEN_W)
    ) decode_i (
        .pkt_len   (pkt_len),
        .pkt_bytes (pkt_bytes),
        .secs      (secs),
        .act       (act)
    );

    assign accept = pkt_valid && act.reply;

    ccr_seconds #(
        .INIT_UNIX (INIT_UNIX)
    ) seconds_i (
        .clk      (clk),
        .rst      (rst),
        .tick     (sec_tick),
        .load     (accept && act.load_time),
        .load_val (act.time_val),
        .secs     (secs)
    );

    ccr_poll_timer #(
        .POLL_DIV (POLL_DIV)
    ) poll_i (
        .clk (clk),
        .rst (rst),
        .en  (poll_en_q),
        .req (poll_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid_q <= 1'b0;
            rsp_len_q   <= '0;
            rsp_bytes_q <= '0;
            poll_en_q   <= 1'b0;
            pend_q      <= SYSREQ_NONE;
            pwr_q       <= 1'b0;
            sysrst_q    <= 1'b0;
        end else begin
            rsp_valid_q <= accept;
            pwr_q       <= (pend_q == SYSREQ_POWER);
            sysrst_q    <= (pend_q == SYSREQ_RESET);
            pend_q      <= accept ? act.sysreq : SYSREQ_NONE;
            if (accept) begin
                rsp_len_q   <= act.len;
                rsp_bytes_q <= act.bytes;
                if (act.poll_wr) begin
                    poll_en_q <= act.poll_val;
                end
            end
        end
    end

    assign rsp_valid  = rsp_valid_q;
    assign rsp_len    = rsp_len_q;
    assign rsp_bytes  = rsp_bytes_q;
    assign pwrdn_req  = pwr_q;
    assign sysrst_req = sysrst_q;

    AST_RSP_AFTER_PKT: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(pkt_valid)); // R11
    AST_RSP_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> (rsp_len == 3'd2 || rsp_len == 3'd3 || rsp_len == 3'd7)); // R11
    AST_RSP_TYPE_CTL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_bytes[7:0] == PKT_TYPE_CTL); // R2
    AST_PWR_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        pwrdn_req |-> ($past(rsp_valid) && $past(rsp_len) == 3'd2)); // R9
    AST_RST_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        sysrst_req |-> ($past(rsp_valid) && $past(rsp_len) == 3'd2)); // R9
    AST_SYSREQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        $onehot0({pwrdn_req, sysrst_req})); // R9

endmodule

// File: tb/ctl_cmd_responder_tb_top.sv
module ctl_cmd_responder_tb_top;

    localparam int MAX_IN   = 8;
    localparam int LEN_W    = 4;
    localparam int CLK_HZ   = 400;
    localparam int POLL_HZ  = 50;
    localparam int POLL_DIV = CLK_HZ / POLL_HZ;
    localparam logic [31:0] RST_SECS = 32'h7C25B080;

    logic                 clk;
    logic                 rst;
    logic                 pkt_valid;
    logic [LEN_W-1:0]     pkt_len;
    logic [MAX_IN*8-1:0]  pkt_bytes;
    logic                 sec_tick;
    logic                 rsp_valid;
    logic [2:0]           rsp_len;
    logic [55:0]          rsp_bytes;
    logic                 poll_req;
    logic                 pwrdn_req;
    logic                 sysrst_req;

    ctl_cmd_responder #(
        .MAX_IN  (MAX_IN),
        .CLK_HZ  (CLK_HZ),
        .POLL_HZ (POLL_HZ)
    ) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pkt_valid  (pkt_valid),
        .pkt_len    (pkt_len),
        .pkt_bytes  (pkt_bytes),
        .sec_tick   (sec_tick),
        .rsp_valid  (rsp_valid),
        .rsp_len    (rsp_len),
        .rsp_bytes  (rsp_bytes),
        .poll_req   (poll_req),
        .pwrdn_req  (pwrdn_req),
        .sysrst_req (sysrst_req)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    int poll_cnt = 0;
    int poll_first = 0;
    int poll_second = 0;

    logic        got_valid, got_valid2, got_pwr0, got_pwr, got_rst0, got_rst;
    logic [2:0]  got_len;
    logic [55:0] got_bytes;
    int          rsp_cyc;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && poll_req) begin
            if (poll_cnt == 0) poll_first = cyc;
            else if (poll_cnt == 1) poll_second = cyc;
            poll_cnt = poll_cnt + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pk(input logic [7:0] b0, input logic [7:0] b1,
                                       input logic [7:0] b2, input logic [7:0] b3,
                                       input logic [7:0] b4, input logic [7:0] b5);
        return {16'h0000, b5, b4, b3, b2, b1, b0};
    endfunction

    function automatic logic [55:0] time_reply(input logic [31:0] s);
        return {s[7:0], s[15:8], s[23:16], s[31:24], 8'h00, 8'h00, 8'h01};
    endfunction

    task automatic send(input int len, input logic [63:0] flat, input bit tick);
        @(posedge clk); #1;
        pkt_valid = 1'b1;
        pkt_len   = LEN_W'(len);
        pkt_bytes = flat;
        sec_tick  = tick;
        @(posedge clk); #1;
        pkt_valid = 1'b0;
        pkt_bytes = '0;
        sec_tick  = 1'b0;
        got_valid = rsp_valid;
        got_len   = rsp_len;
        got_bytes = rsp_bytes;
        got_pwr0  = pwrdn_req;
        got_rst0  = sysrst_req;
        rsp_cyc   = cyc;
        @(posedge clk); #1;
        got_valid2 = rsp_valid;
        got_pwr    = pwrdn_req;
        got_rst    = sysrst_req;
    endtask

    task automatic read_time(input string req, output logic [31:0] t);
        send(2, pk(8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk({req, " read strobe"}, 64'(got_valid), 64'd1);
        chk({req, " read length"}, 64'(got_len), 64'd7);
        chk({req, " read header"}, 64'(got_bytes[23:0]), 64'h000001);
        t = {got_bytes[31:24], got_bytes[39:32], got_bytes[47:40], got_bytes[55:48]};
    endtask

    task automatic tick_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1 sec_tick = 1'b1;
            @(posedge clk); #1 sec_tick = 1'b0;
        end
    endtask

    task automatic load_time(input logic [31:0] v);
        send(6, pk(8'h01, 8'h09, v[31:24], v[23:16], v[15:8], v[7:0]), 1'b0);
    endtask

    task automatic t_reset();
        logic [31:0] t;
        chk("R1 rsp_valid low", 64'(rsp_valid), 64'd0);
        chk("R1 poll_req low", 64'(poll_req), 64'd0);
        chk("R1 requests low", 64'({pwrdn_req, sysrst_req}), 64'd0);
        read_time("R1", t);
        chk("R1 reset seconds", 64'(t), 64'(RST_SECS));
        chk("R4 read reply bytes", 64'(got_bytes), 64'(time_reply(RST_SECS)));
        chk("R11 strobe one cycle", 64'(got_valid2), 64'd0);
    endtask

    task automatic t_ticks();
        logic [31:0] t0, t1;
        read_time("R5", t0);
        tick_n(5);
        read_time("R5", t1);
        chk("R5 five ticks", 64'(t1), 64'(t0 + 32'd5));
    endtask

    task automatic t_load();
        logic [31:0] t;
        load_time(32'h12345678);
        chk("R3 load strobe", 64'(got_valid), 64'd1);
        chk("R3 load length", 64'(got_len), 64'd3);
        chk("R11 load reply bytes", 64'(got_bytes), 64'h000000_00_00_01);
        read_time("R3", t);
        chk("R3 loaded value", 64'(t), 64'h12345678);
        send(6, pk(8'h01, 8'h09, 8'hA0, 8'hB1, 8'hC2, 8'hD3), 1'b1);
        read_time("R5", t);
        chk("R5 load beats tick", 64'(t), 64'hA0B1C2D3);
    endtask

    task automatic t_read_with_tick();
        logic [31:0] t;
        load_time(32'hFFFFFFFF);
        send(2, pk(8'h01, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), 1'b1);
        chk("R4 read sees pre-tick value", 64'(got_bytes), 64'(time_reply(32'hFFFFFFFF)));
        read_time("R5", t);
        chk("R5 wrap to zero", 64'(t), 64'h0);
    endtask

    task automatic t_ack_only();
        logic [7:0] codes [4] = '{8'h13, 8'h19, 8'h14, 8'h21};
        logic [31:0] t;
        load_time(32'h00C0FFEE);
        poll_cnt = 0;
        foreach (codes[i]) begin
            send(2, pk(8'h01, codes[i], 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
            chk("R8 ack strobe", 64'(got_valid), 64'd1);
            chk("R8 ack length", 64'(got_len), 64'd2);
            chk("R8 ack bytes", 64'(got_bytes), 64'h0001);
            chk("R8 no system request", 64'({got_pwr, got_rst, got_pwr0, got_rst0}), 64'd0);
        end
        read_time("R8", t);
        chk("R8 clock untouched", 64'(t), 64'h00C0FFEE);
        chk("R8 no poll pulses", 64'(poll_cnt), 64'd0);
    endtask

    task automatic t_poll();
        send(3, pk(8'h01, 8'h01, 8'h05, 8'h00, 8'h00, 8'h00), 1'b0);
        poll_cnt = 0;
        chk("R6 enable strobe", 64'(got_valid), 64'd1);
        chk("R6 enable length", 64'(got_len), 64'd2);
        chk("R6 enable echo", 64'(got_bytes), 64'h0501);
        repeat (3 * POLL_DIV) @(posedge clk);
        #1;
        chk("R7 first pulse", 64'(poll_first), 64'(rsp_cyc + POLL_DIV - 1));
        chk("R7 pulse period", 64'(poll_second - poll_first), 64'(POLL_DIV));
        chk("R7 pulse count", 64'(poll_cnt), 64'd3);
        send(3, pk(8'h01, 8'h01, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R6 disable echo", 64'(got_bytes), 64'h0001);
        poll_cnt = 0;
        repeat (3 * POLL_DIV) @(posedge clk);
        #1;
        chk("R7 no pulse when disabled", 64'(poll_cnt), 64'd0);
    endtask

    task automatic t_dropped();
        logic [31:0] t;
        load_time(32'h55AA1234);
        send(5, pk(8'h01, 8'h09, 8'h11, 8'h22, 8'h33, 8'h44), 1'b0);
        chk("R10 short load no reply", 64'(got_valid), 64'd0);
        send(2, pk(8'h01, 8'h07, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R10 unknown code no reply", 64'(got_valid), 64'd0);
        send(2, pk(8'h00, 8'h03, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R2 bus type no reply", 64'(got_valid), 64'd0);
        send(6, pk(8'h02, 8'h09, 8'h01, 8'h02, 8'h03, 8'h04), 1'b0);
        chk("R2 error type no reply", 64'(got_valid), 64'd0);
        send(2, pk(8'h04, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R2 power type no request", 64'({got_valid, got_pwr, got_rst}), 64'd0);
        read_time("R10", t);
        chk("R10 clock unchanged", 64'(t), 64'h55AA1234);
        poll_cnt = 0;
        send(2, pk(8'h01, 8'h01, 8'h07, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R10 short poll no reply", 64'(got_valid), 64'd0);
        repeat (3 * POLL_DIV) @(posedge clk);
        #1;
        chk("R10 poll stays off", 64'(poll_cnt), 64'd0);
    endtask

    task automatic t_system();
        send(2, pk(8'h01, 8'h0A, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R9 power ack", 64'({got_valid, got_len}), 64'({1'b1, 3'd2}));
        chk("R9 power ack bytes", 64'(got_bytes), 64'h0001);
        chk("R9 no request with reply", 64'({got_pwr0, got_rst0}), 64'd0);
        chk("R9 power request next cycle", 64'({got_pwr, got_rst}), 64'b10);
        chk("R11 single strobe", 64'(got_valid2), 64'd0);
        @(posedge clk); #1;
        chk("R9 power request one cycle", 64'(pwrdn_req), 64'd0);
        send(2, pk(8'h01, 8'h11, 8'h00, 8'h00, 8'h00, 8'h00), 1'b0);
        chk("R9 restart ack bytes", 64'(got_bytes), 64'h0001);
        chk("R9 restart request next cycle", 64'({got_pwr, got_rst}), 64'b01);
        @(posedge clk); #1;
        chk("R9 restart request one cycle", 64'(sysrst_req), 64'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        rst       = 1'b1;
        pkt_valid = 1'b0;
        pkt_len   = '0;
        pkt_bytes = '0;
        sec_tick  = 1'b0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        t_reset();
        t_ticks();
        t_load();
        t_read_with_tick();
        t_ack_only();
        t_poll();
        t_dropped();
        t_system();
        repeat (4) @(posedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule